// File: doc/BRIEF.md
# LIN master frame header transmitter

This block is the transmit half of a UART extended for LIN bus master use. It drives a single serial line. On request it produces a dominant (low) break whose length in bit times is programmable. After the break it shifts out the bytes that software has queued, typically the 0x55 sync byte, the identifier, and then any response and checksum bytes. Each byte goes out as a standard asynchronous character with one start bit, eight data bits and one or two stop bits.

All bit boundaries follow a single-cycle bit-rate tick supplied from outside. Bytes arrive through a one-byte holding register that has an empty flag. A break request that arrives while a character is being sent waits until that character's last stop bit ends. A byte queued while a break is pending or running stays in the holding register until the break has finished and one idle-high delimiter bit has passed. Writing 0x00 gives a nine-bit low pulse, which can serve as a bus wake-up signal when the bit rate is chosen to match.

Top module: `lin_hdr_tx`

## Requirements
- R1: After synchronous reset, `txd` is 1, `hold_empty` is 1, `tx_idle` is 1 and `brk_pend` is 0.
- R2: A break holds `txd` at 0 for exactly max(`brk_len`, 13) bit periods. A `brk_len` below 13 is clamped to 13.
- R3: If a break is requested while a character is being sent, that character completes all of its stop bits first. The break begins at the bit boundary where the last stop bit ends.
- R4: A `brk_req` pulse sets `brk_pend` in the next cycle. `brk_pend` stays 1 until the bit tick that ends the break, and it falls only on a bit tick.
- R5: A byte written while a break is pending or active stays in the holding register (`hold_empty` = 0) until the break ends. Exactly one idle-high bit period separates the end of the break from that byte's start bit.
- R6: Each character is a start bit (0), then 8 data bits with the least significant bit first, then stop bits (1). Each bit lasts one bit period, and `txd` changes only in the cycle after a `bit_tick`.
- R7: `two_stop` = 1 gives two stop bits and `two_stop` = 0 gives one. The setting is sampled when the character starts.
- R8: A write (`tx_wr`) is accepted only while `hold_empty` is 1. A write while it is 0 is ignored and its byte is never sent. `hold_empty` rises when the held byte moves into the shifter.
- R9: If the holding register is full when a stop bit period ends, the next start bit follows with no idle gap.
- R10: With no character and no break active, `txd` is 1. `tx_idle` is 1 only when no character is being shifted and no break is pending or active.
- R11: Writing 0x00 produces one continuous low pulse of exactly 9 bit periods (start bit plus eight zero data bits), usable as a wake-up signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | Single-cycle pulse marking each bit boundary |
| brk_len | input | LEN_W | Break length in bit periods (clamped to at least 13) |
| brk_req | input | 1 | Pulse that requests a break |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_idle | output | 1 | Shifter and break logic both idle |
| brk_pend | output | 1 | Break requested and not yet finished |

## Verification
If the break counter or its state is wrong, the low run on `txd` has the wrong length, or the delimiter bit is missing. This shows within one break time of the request. A bad shifter phase or shift register misplaces or corrupts bits inside the first character, so a bit-by-bit comparison of `txd` per tick catches it before the stop bit. If the holding flag is wrong, a byte is either dropped or sent twice, or `hold_empty` has the wrong level right after a write. This is visible within one character time.

// File: rtl/lin_hdr_tx_pkg.sv
`timescale 1ns/1ps
package lin_hdr_tx_pkg;

    localparam int unsigned MIN_BRK = 13;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PHASE_W = 4;

    typedef enum logic [1:0] {
        BRK_IDLE = 2'd0,
        BRK_WAIT = 2'd1,
        BRK_LOW  = 2'd2
    } brk_st_t;

    typedef struct packed {
        logic               busy;
        logic [PHASE_W-1:0] phase;  // 0 start, 1..8 data, 9/10 stop
        logic [BYTE_W-1:0]  data;
        logic               two;
    } chr_state_t;

    function automatic logic [PHASE_W-1:0] last_phase(input logic two);
        return two ? PHASE_W'(10) : PHASE_W'(9);
    endfunction

    function automatic logic frame_bit(input chr_state_t s);
        if (!s.busy)
            return 1'b1;
        if (s.phase == '0)
            return 1'b0;
        return s.data[0];
    endfunction

endpackage

// File: rtl/lin_tx_hold.sv
`timescale 1ns/1ps
module lin_tx_hold
    import lin_hdr_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] byte_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            byte_q <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr && !full) begin
            full   <= 1'b1;
            byte_q <= wdata;
        end
    end
endmodule

// File: rtl/lin_brk_unit.sv
`timescale 1ns/1ps
module lin_brk_unit
    import lin_hdr_tx_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             req,
    input  logic             slot_free,
    input  logic [LEN_W-1:0] len,
    output logic             pend,
    output logic             low
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_BRK);

    brk_st_t          st;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] eff;

    assign eff = (len < MIN_LEN) ? MIN_LEN : len;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BRK_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                BRK_IDLE: if (req) st <= BRK_WAIT;
                BRK_WAIT: if (bit_tick && slot_free) begin
                    st  <= BRK_LOW;
                    cnt <= eff - LEN_W'(1);
                end
                BRK_LOW: if (bit_tick) begin
                    if (cnt == '0) st <= BRK_IDLE;
                    else           cnt <= cnt - LEN_W'(1);
                end
                default: st <= BRK_IDLE;
            endcase
        end
    end

    assign pend = (st != BRK_IDLE);
    assign low  = (st == BRK_LOW);
endmodule

// File: rtl/lin_char_shift.sv
`timescale 1ns/1ps
module lin_char_shift
    import lin_hdr_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              two_stop,
    output logic              active,
    output logic              slot_free,
    output logic              line
);
    chr_state_t s;

    always_ff @(posedge clk) begin
        if (rst) begin
            s <= '0;
        end else if (load) begin
            s.busy  <= 1'b1;
            s.phase <= '0;
            s.data  <= byte_in;
            s.two   <= two_stop;
        end else if (bit_tick && s.busy) begin
            if (s.phase == last_phase(s.two)) begin
                s.busy <= 1'b0;
            end else begin
                s.phase <= s.phase + PHASE_W'(1);
                if (s.phase != '0)
                    s.data <= {1'b1, s.data[BYTE_W-1:1]};
            end
        end
    end

    assign active    = s.busy;
    assign slot_free = !s.busy || (s.phase == last_phase(s.two));
    assign line      = frame_bit(s);
endmodule

// File: rtl/lin_hdr_tx.sv
`timescale 1ns/1ps
module lin_hdr_tx
    import lin_hdr_tx_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic [LEN_W-1:0] brk_len,
    input  logic             brk_req,
    input  logic             two_stop,
    input  logic             tx_wr,
    input  logic [7:0]       tx_data,
    output logic             txd,
    output logic             hold_empty,
    output logic             tx_idle,
    output logic             brk_pend
);
    logic              hold_full;
    logic [BYTE_W-1:0] hold_byte;
    logic              chr_active;
    logic              chr_slot;
    logic              chr_line;
    logic              brk_low;
    logic              load;

    assign load = bit_tick && chr_slot && hold_full && !brk_pend;

    lin_tx_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .wr     (tx_wr),
        .wdata  (tx_data),
        .take   (load),
        .full   (hold_full),
        .byte_q (hold_byte)
    );

    lin_brk_unit #(.LEN_W(LEN_W)) u_brk (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .req       (brk_req),
        .slot_free (chr_slot),
        .len       (brk_len),
        .pend      (brk_pend),
        .low       (brk_low)
    );

    lin_char_shift u_chr (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .load      (load),
        .byte_in   (hold_byte),
        .two_stop  (two_stop),
        .active    (chr_active),
        .slot_free (chr_slot),
        .line      (chr_line)
    );

    assign txd        = chr_line && !brk_low;
    assign hold_empty = !hold_full;
    assign tx_idle    = !chr_active && !brk_pend;
endmodule

// File: rtl/lin_hdr_tx_chk.sv
`timescale 1ns/1ps
module lin_hdr_tx_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic brk_req,
    input logic txd,
    input logic hold_empty,
    input logic tx_idle,
    input logic brk_pend
);
    a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> txd);

    a_r10_pend_not_idle: assert property (@(posedge clk) disable iff (rst)
        brk_pend |-> !tx_idle);

    a_r4_req_sets_pend: assert property (@(posedge clk) disable iff (rst)
        brk_req |=> brk_pend);

    a_r4_pend_falls_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_pend) |-> $past(bit_tick));

    a_r6_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(bit_tick));

    a_r8_hold_kept_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!hold_empty && !bit_tick) |=> !hold_empty);
endmodule

bind lin_hdr_tx lin_hdr_tx_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .brk_req    (brk_req),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_idle    (tx_idle),
    .brk_pend   (brk_pend)
);

// File: tb/lin_hdr_tx_tb_top.sv
`timescale 1ns/1ps
module lin_hdr_tx_tb_top;
    localparam int LEN_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bit_tick = 1'b0;
    logic [LEN_W-1:0] brk_len = '0;
    logic             brk_req = 1'b0;
    logic             two_stop = 1'b0;
    logic             tx_wr = 1'b0;
    logic [7:0]       tx_data = '0;
    logic             txd, hold_empty, tx_idle, brk_pend;

    int checks = 0;
    int fails  = 0;

    logic rec   [0:255];
    logic exp_b [0:255];
    int   elen;

    lin_hdr_tx #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .brk_len(brk_len),
        .brk_req(brk_req), .two_stop(two_stop), .tx_wr(tx_wr),
        .tx_data(tx_data), .txd(txd), .hold_empty(hold_empty),
        .tx_idle(tx_idle), .brk_pend(brk_pend)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push(input logic b);
        exp_b[elen] = b;
        elen++;
    endtask

    task automatic push_frame(input logic [7:0] b, input bit two);
        push(1'b0);
        for (int i = 0; i < 8; i++) push(b[i]);
        push(1'b1);
        if (two) push(1'b1);
    endtask

    task automatic push_break(input int n);
        for (int i = 0; i < n; i++) push(1'b0);
        push(1'b1);
    endtask

    task automatic record(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk iff bit_tick);
            #1;
            rec[i] = txd;
        end
    endtask

    task automatic first_low(input int n, output int off);
        off = 0;
        while (off < n && rec[off] === 1'b1) off++;
    endtask

    task automatic check_stream(input int n, input bit align, input string tag);
        int  off = 0;
        int  bi  = -1;
        logic a  = 1'bx;
        if (align) first_low(n, off);
        for (int i = 0; i < elen; i++) begin
            if (bi < 0 && (i + off >= n || rec[i + off] !== exp_b[i])) begin
                bi = i;
                if (i + off < n) a = rec[i + off];
            end
        end
        checks++;
        if (bi >= 0) begin
            fails++;
            $display("FAIL %s: stream bit %0d actual %b expected %b", tag, bi, a, exp_b[bi]);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        while (!hold_empty) @(negedge clk);
        tx_wr = 1'b1;
        tx_data = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pulse_break();
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
    endtask

    task automatic wait_quiet();
        repeat (60) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(txd == 1'b1,        "R1 txd after reset",        txd, 1);
        chk(hold_empty == 1'b1, "R1 hold_empty after reset", hold_empty, 1);
        chk(tx_idle == 1'b1,    "R1 tx_idle after reset",    tx_idle, 1);
        chk(brk_pend == 1'b0,   "R1 brk_pend after reset",   brk_pend, 0);
    endtask

    // short length clamps to 13, one stop bit, sync held during break
    task automatic t_header_clamped();
        brk_len = 6'd5;
        two_stop = 1'b0;
        pulse_break();
        chk(brk_pend == 1'b1, "R4 brk_pend after request", brk_pend, 1);
        chk(tx_idle == 1'b0,  "R10 tx_idle during break",  tx_idle, 0);
        elen = 0;
        push_break(13);
        push_frame(8'h55, 1'b0);
        push_frame(8'h3C, 1'b0);
        for (int i = 0; i < 6; i++) push(1'b1);
        fork
            record(40);
            begin
                write_byte(8'h55);
                repeat (5) @(posedge clk iff bit_tick);
                @(negedge clk);
                chk(hold_empty == 1'b0, "R5 sync held during break", hold_empty, 0);
                write_byte(8'h3C);
            end
        join
        check_stream(40, 1'b0, "R2/R5/R6 clamped break header");
        chk(brk_pend == 1'b0, "R4 brk_pend cleared after break", brk_pend, 0);
        wait_quiet();
    endtask

    // long break, two stop bits, back-to-back bytes
    task automatic t_header_two_stop();
        brk_len = 6'd20;
        two_stop = 1'b1;
        pulse_break();
        elen = 0;
        push_break(20);
        push_frame(8'h55, 1'b1);
        push_frame(8'hA7, 1'b1);
        push_frame(8'h01, 1'b1);
        for (int i = 0; i < 6; i++) push(1'b1);
        fork
            record(60);
            begin
                write_byte(8'h55);
                write_byte(8'hA7);
                write_byte(8'h01);
            end
        join
        check_stream(60, 1'b0, "R2/R7/R9 two-stop header");
        chk(brk_pend == 1'b0, "R4 brk_pend cleared", brk_pend, 0);
        wait_quiet();
    endtask

    // break requested while a character is in flight
    task automatic t_deferred_break();
        brk_len = 6'd14;
        two_stop = 1'b0;
        write_byte(8'hF0);
        elen = 0;
        push_frame(8'hF0, 1'b0);
        push_break(14);
        for (int i = 0; i < 4; i++) push(1'b1);
        fork
            record(34);
            begin
                repeat (3) @(posedge clk iff bit_tick);
                pulse_break();
                chk(brk_pend == 1'b1, "R3 break pending behind char", brk_pend, 1);
                chk(tx_idle == 1'b0,  "R10 not idle while pending",   tx_idle, 0);
            end
        join
        check_stream(34, 1'b1, "R3 deferred break after char");
        wait_quiet();
    endtask

    // wake-up byte, full-register write ignored, idle afterwards
    task automatic t_wake_and_ignore();
        int off;
        int run;
        two_stop = 1'b0;
        elen = 0;
        push_frame(8'h00, 1'b0);
        push_frame(8'hA5, 1'b0);
        for (int i = 0; i < 10; i++) push(1'b1);
        fork
            record(34);
            begin
                write_byte(8'h00);
                write_byte(8'hA5);
                @(negedge clk);
                tx_wr = 1'b1;
                tx_data = 8'hFF;
                @(negedge clk);
                tx_wr = 1'b0;
                chk(hold_empty == 1'b0, "R8 hold stays full on refused write", hold_empty, 0);
            end
        join
        check_stream(34, 1'b1, "R8/R9 refused byte not sent");
        first_low(34, off);
        run = 0;
        while (off + run < 34 && rec[off + run] === 1'b0) run++;
        chk(run == 9, "R11 wake-up low pulse length", run, 9);
        @(negedge clk);
        chk(tx_idle == 1'b1, "R10 tx_idle when done", tx_idle, 1);
        chk(txd == 1'b1,     "R10 line idle high",    txd, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_header_clamped();
                t_header_two_stop();
                t_deferred_break();
                t_wake_and_ignore();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule